// File: doc/BRIEF.md
# Dual-Input Programmable Synthesizer Divider

This block reduces two oscillator signals to comparison rates for a phase detector in a frequency synthesizer. The main ("N") channel takes its input from one of two band paths. The low band (AM) path goes straight to the N counter. The high band (FM) path first passes through a fixed divide-by-two prescaler. The reference ("R") channel divides the reference oscillator on its own. The R ratio sets the tuning step, for example 1 kHz for the low band or 2 kHz for the high band.

All oscillator inputs arrive as single-cycle tick strobes in the system clock domain. Each channel is a 16-bit programmable counter. It reads its ratio from a control word and emits a one-cycle pulse at the end of every period. A ratio below 2 is treated as 2. A ratio change never cuts short the period in progress. A change of band restarts the N path from a clean state.

Top module: `synth_div`

## Requirements
- R1: While reset is asserted, `nPulse` and `rPulse` are low.
- R2: With `bandFm`=0, `nPulse` rises once for every N `amTick` strobes. N is `nRatio` after clamping.
- R3: With `bandFm`=1, `nPulse` rises once for every 2×N `fmTick` strobes. The prescaler passes on every second FM tick.
- R4: The tick input of the unselected band has no effect on `nPulse`.
- R5: `rPulse` rises once for every R `refTick` strobes, whichever band is selected.
- R6: A ratio value of 0 or 1 divides by 2.
- R7: A ratio of 65535 divides by 65535.
- R8: A new ratio value is taken up only at the terminal count of the running period, or at a reload.
- R9: When `bandFm` differs from the band in use, three things happen in that clock cycle. The prescaler and the N counter are cleared. The N ratio is reloaded. Any tick seen in that cycle is not counted.
- R10: A pulse is high for exactly one clock cycle. It appears in the cycle after the edge that samples the terminal tick.
- R11: In the first clock cycle after reset is released, both ratios and the band are loaded and no tick is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| amTick | input | 1 | Low band oscillator tick strobe |
| fmTick | input | 1 | High band oscillator tick strobe |
| refTick | input | 1 | Reference oscillator tick strobe |
| bandFm | input | 1 | Band select: 1 = high band via prescaler, 0 = low band |
| nRatio | input | 16 | Main divider ratio |
| rRatio | input | 16 | Reference divider ratio |
| nPulse | output | 1 | Main divider terminal pulse |
| rPulse | output | 1 | Reference divider terminal pulse |

## Verification
The hardest case to reach is a band switch that lands while the prescaler is half-way through its pair of ticks and the N counter is partly through a period. Only then does a missing clear show up as a short first period.

The stimulus reaches this case in two ways. Random segments flip `bandFm` at random cycles under dense random tick traffic. A directed step also switches band after a partial low band count and then measures the cycles to the first high band pulse. Ratios written mid-period in random traffic exercise the deferred take-up.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int NCH  = 2;
  localparam int CH_N = 0;
  localparam int CH_R = 1;

  typedef struct packed {
    logic [NCH-1:0] tick;
    logic [NCH-1:0] reload;
  } ctrlStrobes_t;
endpackage

// File: rtl/synth_div_counter.sv
module synth_div_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         reload,
  input  logic [W-1:0] ratioIn,
  output logic         pulse
);
  localparam logic [W-1:0] MIN_RATIO = W'(2);
  localparam logic [W-1:0] ONE       = W'(1);

  logic [W-1:0] cnt;
  logic [W-1:0] act;
  logic [W-1:0] ratioSafe;
  logic         atEnd;

  always_comb begin
    ratioSafe = (ratioIn < MIN_RATIO) ? MIN_RATIO : ratioIn;
    atEnd     = (cnt == act - ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      act   <= MIN_RATIO;
      pulse <= 1'b0;
    end else if (reload) begin
      cnt   <= '0;
      act   <= ratioSafe;
      pulse <= 1'b0;
    end else if (tick) begin
      if (atEnd) begin
        cnt   <= '0;
        act   <= ratioSafe;
        pulse <= 1'b1;
      end else begin
        cnt   <= cnt + ONE;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end

  // R7: the count never reaches the active ratio
  a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt < act);
  // R8: the active ratio changes only at a tick or a reload
  a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !reload) |=> $stable(act));
  // R10: a pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse);
  // R9: a reload leaves the counter at zero with no pulse
  a_r9_reload_clears: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> (cnt == '0 && !pulse));
endmodule

// File: rtl/synth_div_path.sv
module synth_div_path
  import synth_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] nRatio,
  input  logic [W-1:0] rRatio,
  output logic         nPulse,
  output logic         rPulse
);
  logic [W-1:0] ratioArr [NCH];
  logic [NCH-1:0] pulseArr;

  always_comb begin
    ratioArr[CH_N] = nRatio;
    ratioArr[CH_R] = rRatio;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    synth_div_counter #(.W(W)) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (strobes.tick[ch]),
      .reload (strobes.reload[ch]),
      .ratioIn(ratioArr[ch]),
      .pulse  (pulseArr[ch])
    );
  end

  assign nPulse = pulseArr[CH_N];
  assign rPulse = pulseArr[CH_R];
endmodule

// File: rtl/synth_div_ctrl.sv
module synth_div_ctrl
  import synth_div_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         amTick,
  input  logic         fmTick,
  input  logic         refTick,
  input  logic         bandFm,
  output ctrlStrobes_t strobes
);
  logic initDone;
  logic bandQ;
  logic pre;
  logic bandChange;
  logic bandTick;

  always_comb begin
    bandChange = initDone && (bandFm != bandQ);
    bandTick   = bandQ ? (fmTick && pre) : amTick;
    strobes.reload[CH_N] = !initDone || bandChange;
    strobes.reload[CH_R] = !initDone;
    strobes.tick[CH_N]   = initDone && !bandChange && bandTick;
    strobes.tick[CH_R]   = initDone && refTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initDone <= 1'b0;
      bandQ    <= 1'b0;
      pre      <= 1'b0;
    end else begin
      initDone <= 1'b1;
      if (!initDone || bandChange) begin
        bandQ <= bandFm;
        pre   <= 1'b0;
      end else if (bandQ && fmTick) begin
        pre <= ~pre;
      end
    end
  end

  // R9: a band change clears the prescaler
  a_r9_pre_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && bandFm != bandQ) |=> !pre);
  // R4: with the high band in use, no N tick comes without an FM tick
  a_r4_no_stray_tick: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && bandQ && !fmTick) |-> !strobes.tick[CH_N]);
  // R3: every FM tick steps the prescaler while the band holds
  a_r3_pre_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && bandQ && bandFm && fmTick) |=> (pre != $past(pre)));
endmodule

// File: rtl/synth_div.sv
module synth_div
  import synth_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         amTick,
  input  logic         fmTick,
  input  logic         refTick,
  input  logic         bandFm,
  input  logic [W-1:0] nRatio,
  input  logic [W-1:0] rRatio,
  output logic         nPulse,
  output logic         rPulse
);
  ctrlStrobes_t strobes;

  synth_div_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .amTick (amTick),
    .fmTick (fmTick),
    .refTick(refTick),
    .bandFm (bandFm),
    .strobes(strobes)
  );

  synth_div_path #(.W(W)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .nRatio (nRatio),
    .rRatio (rRatio),
    .nPulse (nPulse),
    .rPulse (rPulse)
  );
endmodule

// File: tb/synth_div_bench.sv
module synth_div_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic amTick = 1'b0, fmTick = 1'b0, refTick = 1'b0, bandFm = 1'b0;
  logic [15:0] nRatio = 16'd4, rRatio = 16'd4;
  logic nPulse, rPulse;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  bit mInit, mBand, mPre, expN, expR;
  int nCnt, nAct, rCnt, rAct;
  longint cyc = 0, lastN = 0, lastR = 0, nGap = 0, rGap = 0;
  int nSeen = 0;

  always #5 clk = ~clk;

  synth_div u_synth_div (
    .clk(clk), .rstN(rstN), .amTick(amTick), .fmTick(fmTick),
    .refTick(refTick), .bandFm(bandFm), .nRatio(nRatio), .rRatio(rRatio),
    .nPulse(nPulse), .rPulse(rPulse)
  );

  function automatic int clampR(logic [15:0] v);
    return (v < 16'd2) ? 2 : int'(v);
  endfunction

  task automatic check(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic checkInt(string req, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic modelEdge();
    bit nt;
    if (!rstN) begin
      mInit = 0; expN = 0; expR = 0; mPre = 0; mBand = 0;
      return;
    end
    if (!mInit) begin
      mInit = 1; mBand = bandFm; mPre = 0;
      nCnt = 0; nAct = clampR(nRatio); rCnt = 0; rAct = clampR(rRatio);
      expN = 0; expR = 0;
      return;
    end
    expN = 0;
    if (bandFm != mBand) begin
      mBand = bandFm; mPre = 0; nCnt = 0; nAct = clampR(nRatio);
    end else begin
      nt = mBand ? (fmTick && mPre) : amTick;
      if (mBand && fmTick) mPre = !mPre;
      if (nt) begin
        if (nCnt == nAct - 1) begin
          nCnt = 0; nAct = clampR(nRatio); expN = 1;
        end else nCnt++;
      end
    end
    expR = 0;
    if (refTick) begin
      if (rCnt == rAct - 1) begin
        rCnt = 0; rAct = clampR(rRatio); expR = 1;
      end else rCnt++;
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit am, bit fm, bit rf);
    amTick = am; fmTick = fm; refTick = rf;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    cyc++;
    check(tag, "nPulse", nPulse, expN);
    check(tag, "rPulse", rPulse, expR);
    if (nPulse) begin nGap = cyc - lastN; lastN = cyc; nSeen++; end
    if (rPulse) begin rGap = cyc - lastR; lastR = cyc; end
  endtask

  task automatic runUntilN(int maxSteps, bit am, bit fm);
    for (int i = 0; i < maxSteps; i++) begin
      step(am, fm, 1'b0);
      if (nPulse) break;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check("R1", "nPulse in reset", nPulse, 1'b0);
      check("R1", "rPulse in reset", rPulse, 1'b0);
    end
    modelEdge();
    // R11: ticks during the load cycle are not counted
    tag = "R11";
    nRatio = 16'd3; rRatio = 16'd3; bandFm = 1'b0;
    rstN = 1'b1;
    step(1, 1, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    checkInt("R11", "cycle of first nPulse", lastN, 4);

    // R2: low band, N=5, tick every cycle
    tag = "R2";
    nRatio = 16'd5;
    for (int i = 0; i < 20; i++) step(1, 0, 0);
    checkInt("R2", "low band period", nGap, 5);

    // R4: high band selected, only AM ticks arrive
    tag = "R4";
    bandFm = 1'b1; nSeen = 0;
    for (int i = 0; i < 60; i++) step(1, 0, 0);
    checkInt("R4", "pulses from unselected AM", nSeen, 0);

    // R3: high band, N=3, FM tick every cycle
    tag = "R3";
    nRatio = 16'd3;
    for (int i = 0; i < 30; i++) step(0, 1, 0);
    checkInt("R3", "high band period", nGap, 6);

    // R4: low band selected, only FM ticks
    tag = "R4";
    bandFm = 1'b0; nSeen = 0;
    for (int i = 0; i < 60; i++) step(0, 1, 0);
    checkInt("R4", "pulses from unselected FM", nSeen, 0);

    // R6: ratios 0 and 1
    tag = "R6";
    nRatio = 16'd0; rRatio = 16'd1;
    for (int i = 0; i < 20; i++) step(1, 0, 1);
    checkInt("R6", "N ratio 0 period", nGap, 2);
    checkInt("R6", "R ratio 1 period", rGap, 2);

    // R8: ratio change mid-period completes old period first
    tag = "R8";
    nRatio = 16'd4;
    for (int i = 0; i < 12; i++) step(1, 0, 0);
    step(1, 0, 0);
    nRatio = 16'd9;
    runUntilN(10, 1, 0);
    checkInt("R8", "period in progress kept", nGap, 4);
    runUntilN(20, 1, 0);
    checkInt("R8", "new period", nGap, 9);

    // R9: switch band part-way through, first FM period is clean
    tag = "R9";
    nRatio = 16'd4;
    runUntilN(20, 1, 0);
    step(1, 0, 0); step(1, 0, 0);
    bandFm = 1'b1;
    step(1, 1, 0);
    begin
      int n = 0;
      for (int i = 0; i < 20; i++) begin
        step(0, 1, 0); n++;
        if (nPulse) break;
      end
      checkInt("R9", "steps to first high band pulse", n, 8);
    end

    // R5/R2/R3/R8/R9: random segments
    for (int seg = 0; seg < 10; seg++) begin
      tag = (seg % 2 == 0) ? "R5" : "R9";
      for (int i = 0; i < 1500; i++) begin
        int p;
        p = int'($urandom_range(0, 99));
        if ($urandom_range(0, 199) == 0) bandFm = ~bandFm;
        if ($urandom_range(0, 99) == 0) nRatio = 16'($urandom_range(0, 20));
        if ($urandom_range(0, 99) == 0) rRatio = 16'($urandom_range(0, 20));
        step(p < 60, $urandom_range(0, 99) < 70, $urandom_range(0, 99) < p);
      end
    end

    // R7: maximum reference ratio
    tag = "R7";
    rRatio = 16'hFFFF;
    for (int i = 0; i < 60; i++) step(0, 0, 1);
    begin
      longint startR;
      startR = lastR;
      for (int i = 0; i < 65540; i++) begin
        step(0, 0, 1);
        if (lastR != startR) break;
      end
      for (int i = 0; i < 65540; i++) begin
        step(0, 0, 1);
        if (rPulse) break;
      end
    end
    checkInt("R7", "R ratio 65535 period", rGap, 65535);

    // R10: a pulse is followed by a low cycle
    tag = "R10";
    nRatio = 16'd2;
    for (int i = 0; i < 10; i++) begin
      step(1, 0, 0);
      if (nPulse) begin
        step(1, 0, 0);
        check("R10", "nPulse after pulse", nPulse, 1'b0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule